// File: doc/BRIEF.md
# Firmware-Steered I2C Slave Byte Shifter

This block moves single bytes between an I2C bus and a CPU-side data register while the bus master supplies the clock. Firmware decides everything that is protocol-level: whether the address matches, which direction the transfer runs, and whether to acknowledge. The hardware only shifts bits in time with the master's SCL, spots START and STOP, and holds SCL low at the end of every phase until firmware has written the data register again.

A transfer runs as alternating phases. A data phase is eight bits and an acknowledge phase is one bit. After a START, a receive data phase is armed on its own so that the address byte is captured. Each later phase begins with a write to the data register. For a receive phase firmware writes 0xFF. For a transmit phase it writes the outgoing byte. In an acknowledge phase 0x7F pulls SDA low and 0xFF leaves it released. Every completed phase sets an interrupt flag and stretches SCL. A control bit turns off both stretching and the interrupt, and each START clears that bit again.

Top module: `i2c_sw_slave`

## Requirements
- R1: After reset, data_rdata reads 0x00, irq_o, nostretch_o, scl_low_o and sda_low_o are all 0.
- R2: A START arms a receive data phase. After eight SCL pulses data_rdata holds the sampled bits with the first one in bit 7, and irq_o and scl_low_o are both 1.
- R3: A data register write clears irq_o and scl_low_o on the next cycle. In an acknowledge phase, bit 7 of the written value (0x7F gives 0, 0xFF gives 1) is the level seen on SDA while SCL is high.
- R4: In a transmit data phase the written byte appears on SDA with bit 7 first, one bit per SCL pulse. sda_low_o changes only while the bus SCL is low.
- R5: When a one-bit acknowledge phase ends, irq_o and scl_low_o are set, and bit 0 of data_rdata holds the SDA level sampled in that bit (0 means acknowledge).
- R6: While nostretch_o is 1, scl_low_o stays 0 and irq_o does not rise, even when a phase completes.
- R7: A START clears nostretch_o. If a control write lands in the same cycle that the START is detected, the START wins.
- R8: A STOP releases SCL, does not set irq_o, and resets the bit count, so that the next START captures a full byte from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr | input | 1 | One-cycle strobe that writes the data register |
| data_wdata | input | 8 | Value to write: outgoing byte, 0xFF to receive or release, 0x7F to acknowledge |
| data_rdata | output | 8 | Shift register contents: received byte or sampled acknowledge bit |
| ctl_wr | input | 1 | One-cycle strobe that writes the stretch-disable bit |
| ctl_nostretch | input | 1 | Value for the stretch-disable bit |
| nostretch_o | output | 1 | Current stretch-disable bit |
| irq_o | output | 1 | Phase-complete interrupt flag |
| scl_in | input | 1 | Bus SCL level |
| sda_in | input | 1 | Bus SDA level |
| scl_low_o | output | 1 | Open-drain pull-down enable for SCL |
| sda_low_o | output | 1 | Open-drain pull-down enable for SDA |

## Verification
Firmware writing the stretch-disable bit and the synchronized detection of a START can both update that bit in the same clock. The bench counts the synchronizer and edge-detect registers and places a one-cycle control write exactly on the detection cycle. It then requires the bit to read back as 0. A control write issued after the START has settled must still set the bit, which shows the priority belongs to the START and is not just a dead write path.

// File: rtl/i2c_sw_slave_pkg.sv
package i2c_sw_slave_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              samp;
        logic              armed;
        logic              got_rise;
        logic              ack_phase;
        logic              stretch;
        logic              irq;
        logic              nostretch;
    } core_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic sync_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned W = STAGES + 1;

    logic [W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[W-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic scl_sync,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    always_comb begin
        start_o = scl_sync & sda_fall;
        stop_o  = scl_sync & sda_rise;
    end
endmodule

// File: rtl/i2c_sw_slave.sv
module i2c_sw_slave
    import i2c_sw_slave_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_wdata,
    output logic [BYTE_W-1:0] data_rdata,
    input  logic              ctl_wr,
    input  logic              ctl_nostretch,
    output logic              nostretch_o,
    output logic              irq_o,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_low_o,
    output logic              sda_low_o
);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(BYTE_W - 1);

    logic scl_sync, scl_rise, scl_fall;
    logic sda_sync, sda_rise, sda_fall;
    logic start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_in),
        .sync_o(scl_sync), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_in),
        .sync_o(sda_sync), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    i2c_bus_cond u_cond (
        .scl_sync(scl_sync), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(start_det), .stop_o(stop_det)
    );

    core_state_t st_d, st_q;
    logic [CNT_W-1:0] last_bit;

    always_comb begin
        st_d     = st_q;
        last_bit = st_q.ack_phase ? '0 : DATA_LAST;

        // firmware control bit (a START below overrides it)
        if (ctl_wr) st_d.nostretch = ctl_nostretch;

        if (data_wr) begin
            st_d.shreg    = data_wdata;
            st_d.cnt      = '0;
            st_d.armed    = 1'b1;
            st_d.got_rise = 1'b0;
            st_d.stretch  = 1'b0;
            st_d.irq      = 1'b0;
        end else if (st_q.armed) begin
            if (scl_rise) begin
                st_d.samp     = sda_sync;
                st_d.got_rise = 1'b1;
            end
            if (scl_fall && st_q.got_rise) begin
                st_d.shreg    = {st_q.shreg[BYTE_W-2:0], st_q.samp};
                st_d.got_rise = 1'b0;
                if (st_q.cnt == last_bit) begin
                    st_d.cnt       = '0;
                    st_d.armed     = 1'b0;
                    st_d.ack_phase = ~st_q.ack_phase;
                    if (!st_d.nostretch) begin
                        st_d.stretch = 1'b1;
                        st_d.irq     = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        if (start_det) begin
            st_d.nostretch = 1'b0;
            st_d.shreg     = '1;
            st_d.cnt       = '0;
            st_d.armed     = 1'b1;
            st_d.got_rise  = 1'b0;
            st_d.stretch   = 1'b0;
            st_d.ack_phase = 1'b0;
        end else if (stop_det) begin
            st_d.cnt       = '0;
            st_d.armed     = 1'b0;
            st_d.got_rise  = 1'b0;
            st_d.stretch   = 1'b0;
            st_d.ack_phase = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.samp     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_rdata  = st_q.shreg;
    assign nostretch_o = st_q.nostretch;
    assign irq_o       = st_q.irq;
    assign scl_low_o   = st_q.stretch & ~st_q.nostretch;
    assign sda_low_o   = st_q.armed & ~st_q.shreg[BYTE_W-1];
endmodule

// File: rtl/i2c_sw_slave_chk.sv
module i2c_sw_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic data_wr,
    input logic irq_o,
    input logic scl_low_o,
    input logic nostretch_o,
    input logic start_det,
    input logic stop_det
);
    assert_irq_with_stretch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> scl_low_o);

    assert_write_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (!irq_o && !scl_low_o));

    assert_quiet_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nostretch_o |-> !$rose(irq_o));

    assert_start_clears_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !nostretch_o);

    assert_stop_releases_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !scl_low_o);

    assert_stop_sets_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !irq_o) |=> !irq_o);
endmodule

bind i2c_sw_slave i2c_sw_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .irq_o(irq_o),
    .scl_low_o(scl_low_o), .nostretch_o(nostretch_o),
    .start_det(start_det), .stop_det(stop_det)
);

// File: tb/tb_i2c_sw_slave.sv
module tb_i2c_sw_slave;
    localparam int H = 8;
    localparam int NVEC = 6;
    // {transmit, byte, ack bit}
    localparam logic [9:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'hA5, 1'b0},
        {1'b0, 8'h3C, 1'b1},
        {1'b0, 8'h00, 1'b0},
        {1'b1, 8'h96, 1'b0},
        {1'b1, 8'hFF, 1'b1},
        {1'b1, 8'h01, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_wr = 1'b0;
    logic [7:0] data_wdata = 8'h00;
    logic [7:0] data_rdata;
    logic ctl_wr = 1'b0;
    logic ctl_nostretch = 1'b0;
    logic nostretch_o, irq_o, scl_low_o, sda_low_o;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic scl_bus, sda_bus;
    int errors = 0;
    int checks = 0;
    int stretch_cycles = 0;
    int sda_bad = 0;
    logic sda_prev = 1'b0;

    always #10 clk = ~clk;

    assign scl_bus = scl_m & ~scl_low_o;
    assign sda_bus = sda_m & ~sda_low_o;

    i2c_sw_slave dut (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .ctl_wr(ctl_wr), .ctl_nostretch(ctl_nostretch),
        .nostretch_o(nostretch_o), .irq_o(irq_o), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
    );

    always begin
        @(posedge clk);
        #3;
        if (scl_low_o) stretch_cycles++;
        if (rst_n && (sda_low_o !== sda_prev) && scl_bus) sda_bad++;
        sda_prev = sda_low_o;
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fw_data(input logic [7:0] v);
        data_wr = 1'b1; data_wdata = v;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic fw_ctl(input logic v);
        ctl_wr = 1'b1; ctl_nostretch = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic r);
        sda_m = b; idle(H);
        scl_high(); idle(H);
        r = sda_bus;
        scl_m = 1'b0; idle(H);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], r);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, r);
            v[i] = r;
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(H);
        scl_high(); idle(H);
        sda_m = 1'b0; idle(H);
        scl_m = 1'b0; idle(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(H);
        scl_high(); idle(H);
        sda_m = 1'b1; idle(H);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic r;
        int s0;
        idle(3);
        // R1 reset state
        chk("R1", "rdata", data_rdata, 8'h00);
        chk("R1", "irq", {7'd0, irq_o}, 8'h00);
        chk("R1", "nostretch", {7'd0, nostretch_o}, 8'h00);
        chk("R1", "drives", {6'd0, scl_low_o, sda_low_o}, 8'h00);
        rst_n = 1'b1;
        idle(4);

        for (int k = 0; k < NVEC; k++) begin
            logic       tx;
            logic [7:0] bv;
            logic       ab;
            {tx, bv, ab} = VEC[k];
            bus_start();
            if (!tx) begin
                send_byte(bv);
                chk("R2", "rx byte", data_rdata, bv);
                chk("R2", "irq+stretch", {6'd0, irq_o, scl_low_o}, 8'h03);
                fw_data(ab ? 8'hFF : 8'h7F);
                chk("R3", "released", {6'd0, irq_o, scl_low_o}, 8'h00);
                bit_cycle(1'b1, r);
                chk("R3", "ack level", {7'd0, r}, {7'd0, ab});
                chk("R5", "ack end irq+stretch", {6'd0, irq_o, scl_low_o}, 8'h03);
            end else begin
                send_byte(8'hA1);
                fw_data(8'h7F);
                bit_cycle(1'b1, r);
                chk("R3", "addr ack low", {7'd0, r}, 8'h00);
                fw_data(bv);
                read_byte(rb);
                chk("R4", "tx byte", rb, bv);
                chk("R4", "irq+stretch", {6'd0, irq_o, scl_low_o}, 8'h03);
                fw_data(8'hFF);
                bit_cycle(ab, r);
                chk("R5", "ack end irq+stretch", {6'd0, irq_o, scl_low_o}, 8'h03);
                chk("R5", "master ack bit", {7'd0, data_rdata[0]}, {7'd0, ab});
            end
            fw_data(8'hFF);
            bus_stop();
            chk("R8", "after stop", {6'd0, irq_o, scl_low_o}, 8'h00);
        end

        // R6: stretch disabled, a full byte completes silently
        bus_start();
        fw_ctl(1'b1);
        s0 = stretch_cycles;
        send_byte(8'h5A);
        idle(H);
        chk("R6", "irq", {7'd0, irq_o}, 8'h00);
        chk("R6", "stretch cycles", 8'(stretch_cycles - s0), 8'h00);
        bus_stop();
        chk("R7", "kept over stop", {7'd0, nostretch_o}, 8'h01);
        bus_start();
        chk("R7", "start clears", {7'd0, nostretch_o}, 8'h00);
        fw_data(8'hFF);
        bus_stop();

        // R7: control write on the START detection cycle
        sda_m = 1'b1; scl_m = 1'b1; idle(H);
        sda_m = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        ctl_wr = 1'b1; ctl_nostretch = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R7", "start wins collision", {7'd0, nostretch_o}, 8'h00);
        idle(2);
        fw_ctl(1'b1);
        chk("R7", "later write sets", {7'd0, nostretch_o}, 8'h01);
        scl_m = 1'b0; idle(H);
        bus_stop();
        fw_ctl(1'b0);

        // R8: STOP in mid-byte, then a clean byte
        bus_start();
        send_byte(8'hFF);
        fw_data(8'hFF);
        bus_stop();
        bus_start();
        for (int i = 0; i < 3; i++) bit_cycle(1'b0, r);
        bus_stop();
        chk("R8", "mid-byte stop", {6'd0, irq_o, scl_low_o}, 8'h00);
        bus_start();
        send_byte(8'hC3);
        chk("R8", "count reset byte", data_rdata, 8'hC3);
        chk("R8", "count reset irq", {7'd0, irq_o}, 8'h01);
        fw_data(8'hFF);
        bus_stop();

        chk("R4", "sda changed while scl high", 8'(sda_bad), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule